// File: doc/BRIEF.md
# Differential Serial ADC Readout Controller

This block sits on the host side of a 12-bit three-wire serial converter and runs each sample frame itself. A request on `start_req` makes the controller pull the active-low conversion-start line down for a set pulse width. It then releases the line and drives exactly sixteen serial clocks. During those clocks the converter both converts and shifts its result out on one data line. The controller samples that line at each serial-clock falling edge, keeps the twelve bits that sit at a configurable position in the frame, and formats them as a 16-bit word. The word carries a one-cycle valid strobe.

The serial clock comes from the system clock through a divider parameter that sets the length of each phase. A mode input chooses how the word is formatted: zero-extended straight binary for unipolar inputs, or sign-extended two's complement for bipolar inputs. The converter's next acquisition window opens at a fixed rising edge two clocks before the end of a frame, so the controller enforces a minimum time from that edge to the next conversion start. Requests that arrive too early are held and served later, and are never lost. Two wake inputs cover the converter's power states. After a full power-down exit, the controller waits a programmable number of cycles before it starts any conversion. After a partial power-down exit, it runs the next frame as a restart and discards that frame's result.

Top module: `adc_frame_ctrl`

## Requirements
- R1: Out of reset, and whenever no frame is running, `adc_cnvst_n` is 1, `adc_sclk` is 1, `result_valid` is 0 and `result` is 0. With no request, no frame starts.
- R2: A frame holds `adc_cnvst_n` low for exactly CNV_LOW system cycles. `adc_sclk` first falls in the cycle in which `adc_cnvst_n` returns high, which is CNV_LOW cycles after the fall. The frame then produces exactly FRAME_CLKS (16) serial clocks. Each clock has a low phase followed by a high phase, and each phase lasts HALF_DIV system cycles. `adc_sclk` never goes low while `adc_cnvst_n` is low.
- R3: Serial clocks are numbered from 1, starting at the first falling edge after the conversion-start pulse. The result field is taken from `adc_dout` as sampled at the falling edges of clocks MSB_CLK through MSB_CLK+11 (default 2 through 13), most significant bit first. Bits on all other clocks have no effect on the result.
- R4: With `bipolar` = 0, `result` equals the 12-bit field zero-extended to 16 bits, so bits 15:12 are 0.
- R5: With `bipolar` = 1, the 12-bit field is read as two's complement and `result` is that value sign-extended to 16 bits. For example, field 0x800 gives 0xF800 and field 0x7FF gives 0x07FF.
- R6: `result_valid` is high for exactly one system cycle per delivered result. It rises HALF_DIV cycles after the last serial-clock rising edge of the frame, which is when that clock's high phase ends.
- R7: No conversion-start fall happens before the previous frame has produced all FRAME_CLKS clocks. At least ACQ_CYC system cycles pass between rising edge FRAME_CLKS-2 (the 14th) of one frame and the next conversion-start fall.
- R8: A request that arrives during a frame or a wait is held pending and served once the frame or wait ends. Any number of requests during one frame produce exactly one extra frame.
- R9: After a pulse on `wake_full`, no conversion-start fall happens for at least PWRUP_CYC system cycles. A request made meanwhile is served after the wait ends.
- R10: After a pulse on `wake_partial`, the next frame that completes produces no `result_valid`, and `result` keeps its previous value. The frame after it delivers its result normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request one conversion frame (one-cycle pulse) |
| bipolar | input | 1 | 1: two's complement sign-extended result; 0: zero-extended straight binary |
| wake_full | input | 1 | Pulse: converter leaves full power-down, start the power-up wait |
| wake_partial | input | 1 | Pulse: converter leaves partial power-down, discard the next frame |
| adc_dout | input | 1 | Serial data from the converter |
| adc_cnvst_n | output | 1 | Active-low conversion start to the converter |
| adc_sclk | output | 1 | Serial clock to the converter, idles high |
| result | output | 16 | Formatted sample word |
| result_valid | output | 1 | One-cycle strobe marking a new `result` |

## Verification
A corrupted phase or clock counter in the sequencer shows up at the pins within one serial-clock phase. It appears as a conversion-start pulse or clock phase of the wrong length, or as a frame with a wrong number of rising edges. The next conversion start exposes a wrong edge count, and the first valid strobe exposes a misplaced end of frame. A wrong capture position or a sign-extension error appears in the first result word after the fault, because the data patterns put ones and zeros in the ignored clock slots. A stuck pending flag, acquisition counter or power-up counter shows within one frame: there is either a frame too many, a frame too few, or a conversion-start fall that comes too close to the 14th rising edge or to the wake pulse.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CNV  = 2'd1,
        SQ_LO   = 2'd2,
        SQ_HI   = 2'd3
    } sq_state_e;

endpackage

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int HALF_DIV   = 3,
    parameter int CNV_LOW    = 3,
    parameter int FRAME_CLKS = 16,
    parameter int DATA_W     = 12,
    parameter int MSB_CLK    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic launch,
    output logic take,
    output logic done,
    output logic acq_mark,
    output logic cnvst_n,
    output logic sclk
);
    localparam int PH_MAX   = (HALF_DIV > CNV_LOW) ? HALF_DIV : CNV_LOW;
    localparam int PH_W     = $clog2(PH_MAX + 1);
    localparam int K_W      = $clog2(FRAME_CLKS + 1);
    localparam int ACQ_RISE = FRAME_CLKS - 2;
    localparam logic [PH_W-1:0] HALF_LD = PH_W'(HALF_DIV - 1);
    localparam logic [PH_W-1:0] CNV_LD  = PH_W'(CNV_LOW - 1);
    localparam logic [K_W-1:0]  K_LAST  = K_W'(FRAME_CLKS);
    localparam logic [K_W-1:0]  K_ACQ   = K_W'(ACQ_RISE);

    typedef struct packed {
        sq_state_e       st;
        logic [PH_W-1:0] ph;
        logic [K_W-1:0]  k;
        logic            cnvst_n;
        logic            sclk;
    } seq_t;

    seq_t q, d;

    function automatic logic in_field(input logic [K_W-1:0] kk);
        return (int'(kk) >= MSB_CLK) && (int'(kk) < MSB_CLK + DATA_W);
    endfunction

    always_comb begin
        d        = q;
        launch   = 1'b0;
        take     = 1'b0;
        done     = 1'b0;
        acq_mark = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                if (go) begin
                    d.st      = SQ_CNV;
                    d.cnvst_n = 1'b0;
                    d.ph      = CNV_LD;
                    launch    = 1'b1;
                end
            end
            SQ_CNV: begin
                if (q.ph == '0) begin
                    d.st      = SQ_LO;
                    d.cnvst_n = 1'b1;
                    d.sclk    = 1'b0;
                    d.k       = K_W'(1);
                    d.ph      = HALF_LD;
                    take      = in_field(K_W'(1));
                end else begin
                    d.ph = q.ph - PH_W'(1);
                end
            end
            SQ_LO: begin
                if (q.ph == '0) begin
                    d.st     = SQ_HI;
                    d.sclk   = 1'b1;
                    d.ph     = HALF_LD;
                    acq_mark = (q.k == K_ACQ);
                end else begin
                    d.ph = q.ph - PH_W'(1);
                end
            end
            SQ_HI: begin
                if (q.ph == '0) begin
                    if (q.k == K_LAST) begin
                        d.st = SQ_IDLE;
                        d.k  = '0;
                        done = 1'b1;
                    end else begin
                        d.st   = SQ_LO;
                        d.sclk = 1'b0;
                        d.k    = q.k + K_W'(1);
                        d.ph   = HALF_LD;
                        take   = in_field(q.k + K_W'(1));
                    end
                end else begin
                    d.ph = q.ph - PH_W'(1);
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= SQ_IDLE;
            q.ph      <= '0;
            q.k       <= '0;
            q.cnvst_n <= 1'b1;
            q.sclk    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cnvst_n = q.cnvst_n;
    assign sclk    = q.sclk;

endmodule

// File: rtl/adc_rd_pace.sv
module adc_rd_pace #(
    parameter int ACQ_CYC   = 13,
    parameter int PWRUP_CYC = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic launch,
    input  logic acq_mark,
    input  logic wake_full,
    output logic want,
    output logic ready
);
    localparam int ACQ_W = $clog2(ACQ_CYC + 1);
    localparam int WT_W  = $clog2(PWRUP_CYC + 1);
    localparam logic [ACQ_W-1:0] ACQ_TOP = ACQ_W'(ACQ_CYC);
    localparam logic [WT_W-1:0]  WT_TOP  = WT_W'(PWRUP_CYC);

    typedef struct packed {
        logic             pend;
        logic [ACQ_W-1:0] acq;
        logic [WT_W-1:0]  wt;
    } pace_t;

    pace_t q, d;

    always_comb begin
        d      = q;
        d.pend = (q.pend | start_req) & ~launch;
        if (acq_mark) begin
            d.acq = '0;
        end else if (q.acq < ACQ_TOP) begin
            d.acq = q.acq + ACQ_W'(1);
        end
        if (wake_full) begin
            d.wt = WT_TOP;
        end else if (q.wt != '0) begin
            d.wt = q.wt - WT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.pend <= 1'b0;
            q.acq  <= ACQ_TOP;
            q.wt   <= '0;
        end else begin
            q <= d;
        end
    end

    assign want  = start_req | q.pend;
    assign ready = (q.acq >= ACQ_TOP) && (q.wt == '0) && !wake_full;

endmodule

// File: rtl/adc_rd_capt.sv
module adc_rd_capt #(
    parameter int DATA_W = 12,
    parameter int OUT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             din,
    input  logic             done,
    input  logic             bipolar,
    input  logic             wake_partial,
    output logic [OUT_W-1:0] result,
    output logic             valid
);
    localparam int EXT_W = OUT_W - DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [OUT_W-1:0]  res;
        logic              valid;
        logic              disc;
    } capt_t;

    capt_t q, d;
    logic [EXT_W-1:0] ext;

    always_comb begin
        ext = bipolar ? {EXT_W{q.sh[DATA_W-1]}} : '0;
    end

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (take) begin
            d.sh = {q.sh[DATA_W-2:0], din};
        end
        if (done) begin
            if (!q.disc) begin
                d.res   = {ext, q.sh};
                d.valid = 1'b1;
            end
            d.disc = 1'b0;
        end
        if (wake_partial) begin
            d.disc = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sh    <= '0;
            q.res   <= '0;
            q.valid <= 1'b0;
            q.disc  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign result = q.res;
    assign valid  = q.valid;

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
    parameter int HALF_DIV   = 3,
    parameter int CNV_LOW    = 3,
    parameter int FRAME_CLKS = 16,
    parameter int DATA_W     = 12,
    parameter int OUT_W      = 16,
    parameter int MSB_CLK    = 2,
    parameter int ACQ_CYC    = 13,
    parameter int PWRUP_CYC  = 200000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             bipolar,
    input  logic             wake_full,
    input  logic             wake_partial,
    input  logic             adc_dout,
    output logic             adc_cnvst_n,
    output logic             adc_sclk,
    output logic [OUT_W-1:0] result,
    output logic             result_valid
);
    logic want, ready, launch, take, done, acq_mark;

    adc_rd_pace #(
        .ACQ_CYC  (ACQ_CYC),
        .PWRUP_CYC(PWRUP_CYC)
    ) u_pace (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_req(start_req),
        .launch   (launch),
        .acq_mark (acq_mark),
        .wake_full(wake_full),
        .want     (want),
        .ready    (ready)
    );

    adc_rd_seq #(
        .HALF_DIV  (HALF_DIV),
        .CNV_LOW   (CNV_LOW),
        .FRAME_CLKS(FRAME_CLKS),
        .DATA_W    (DATA_W),
        .MSB_CLK   (MSB_CLK)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (want & ready),
        .launch  (launch),
        .take    (take),
        .done    (done),
        .acq_mark(acq_mark),
        .cnvst_n (adc_cnvst_n),
        .sclk    (adc_sclk)
    );

    adc_rd_capt #(
        .DATA_W(DATA_W),
        .OUT_W (OUT_W)
    ) u_capt (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .din         (adc_dout),
        .done        (done),
        .bipolar     (bipolar),
        .wake_partial(wake_partial),
        .result      (result),
        .valid       (result_valid)
    );

endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk #(
    parameter int HALF_DIV   = 3,
    parameter int CNV_LOW    = 3,
    parameter int FRAME_CLKS = 16,
    parameter int DATA_W     = 12,
    parameter int OUT_W      = 16,
    parameter int PWRUP_CYC  = 200000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wake_full,
    input logic             bipolar,
    input logic             adc_cnvst_n,
    input logic             adc_sclk,
    input logic [OUT_W-1:0] result,
    input logic             result_valid
);
    logic cn_p, sc_p, seen;
    int   low_cnt, ph_cnt, rise_cnt, wk_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cn_p     <= 1'b1;
            sc_p     <= 1'b1;
            seen     <= 1'b0;
            low_cnt  <= 0;
            ph_cnt   <= HALF_DIV;
            rise_cnt <= 0;
            wk_cnt   <= PWRUP_CYC;
        end else begin
            cn_p    <= adc_cnvst_n;
            sc_p    <= adc_sclk;
            low_cnt <= adc_cnvst_n ? 0 : low_cnt + 1;
            ph_cnt  <= (adc_sclk != sc_p) ? 1 : ((ph_cnt < HALF_DIV) ? ph_cnt + 1 : ph_cnt);
            if (cn_p && !adc_cnvst_n) begin
                seen     <= 1'b1;
                rise_cnt <= 0;
            end else if (!sc_p && adc_sclk) begin
                rise_cnt <= rise_cnt + 1;
            end
            wk_cnt <= wake_full ? 1 : ((wk_cnt < PWRUP_CYC) ? wk_cnt + 1 : wk_cnt);
        end
    end

    assert_cnv_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_cnvst_n && !cn_p) |-> (low_cnt == CNV_LOW));

    assert_sclk_high_in_cnv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cnvst_n |-> adc_sclk);

    assert_phase_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sclk != sc_p) |-> (ph_cnt >= HALF_DIV));

    assert_unipolar_zext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !bipolar && $stable(bipolar)) |-> (result[OUT_W-1:DATA_W] == '0));

    assert_bipolar_sext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && bipolar && $stable(bipolar))
            |-> (result[OUT_W-1:DATA_W] == {(OUT_W-DATA_W){result[DATA_W-1]}}));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    assert_frame_complete_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cn_p && !adc_cnvst_n) |-> (!seen || rise_cnt == FRAME_CLKS));

    assert_powerup_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cn_p && !adc_cnvst_n) |-> (wk_cnt >= PWRUP_CYC));

endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk #(
    .HALF_DIV  (HALF_DIV),
    .CNV_LOW   (CNV_LOW),
    .FRAME_CLKS(FRAME_CLKS),
    .DATA_W    (DATA_W),
    .OUT_W     (OUT_W),
    .PWRUP_CYC (PWRUP_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_full   (wake_full),
    .bipolar     (bipolar),
    .adc_cnvst_n (adc_cnvst_n),
    .adc_sclk    (adc_sclk),
    .result      (result),
    .result_valid(result_valid)
);

// File: tb/tb_adc_frame_ctrl.sv
`timescale 1ns/1ps
module tb_adc_frame_ctrl;
    localparam int HALF = 3;
    localparam int CNVL = 3;
    localparam int ACQ  = 25;
    localparam int PWR  = 60;
    localparam int NV   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0, bipolar = 1'b0, wake_full = 1'b0, wake_partial = 1'b0;
    logic adc_dout = 1'b0;
    logic adc_cnvst_n, adc_sclk, result_valid;
    logic [15:0] result;

    always #5 clk = ~clk;

    adc_frame_ctrl #(
        .HALF_DIV(HALF), .CNV_LOW(CNVL), .ACQ_CYC(ACQ), .PWRUP_CYC(PWR)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .bipolar(bipolar),
        .wake_full(wake_full), .wake_partial(wake_partial), .adc_dout(adc_dout),
        .adc_cnvst_n(adc_cnvst_n), .adc_sclk(adc_sclk), .result(result),
        .result_valid(result_valid)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // converter model: bit for clock k is frame[16-k]; changes after each sclk rise
    logic [15:0] tb_frame = 16'h0, fr_l = 16'h0;
    int bi = 16;
    always @(negedge adc_cnvst_n) begin
        fr_l = tb_frame;
        bi = 1;
        adc_dout = fr_l[15];
    end
    always @(posedge adc_sclk) begin
        if (bi < 16) begin
            #2;
            adc_dout = fr_l[15 - bi];
            bi = bi + 1;
        end
    end

    // pin monitor
    logic cn_p = 1'b1, sc_p = 1'b1, v_p = 1'b0;
    int low_w = 0, ph_w = 0, rises = 0, gap14 = 1000, since_wake = 1000;
    int to_fall = 0, hi_since = 0, frames = 0, valids = 0;
    bit seen = 0, first_pend = 0;
    logic [15:0] last_res = 16'h0;

    always @(negedge clk) begin
        if (rst_n) begin
            gap14++;
            since_wake++;
            hi_since++;
            if (wake_full) since_wake = 0;
            if (cn_p && !adc_cnvst_n) begin
                frames++;
                if (seen) begin
                    chk(rises == 16, "R2 rising edges per frame", rises, 16);
                    chk(gap14 >= ACQ, "R7 acquisition gap", gap14, ACQ);
                end
                chk(since_wake >= PWR, "R9 power-up wait before start", since_wake, PWR);
                seen = 1; rises = 0; low_w = 1; to_fall = 0; first_pend = 1;
            end else begin
                if (!adc_cnvst_n) low_w++;
                if (first_pend) to_fall++;
            end
            if (!cn_p && adc_cnvst_n)
                chk(low_w == CNVL, "R2 conversion-start width", low_w, CNVL);
            if (adc_sclk != sc_p) begin
                if (first_pend) begin
                    chk(to_fall == CNVL, "R2 start to first sclk fall", to_fall, CNVL);
                    first_pend = 0;
                end else begin
                    chk(ph_w == HALF, "R2 sclk phase width", ph_w, HALF);
                end
                ph_w = 1;
                if (adc_sclk) begin
                    rises++;
                    hi_since = 0;
                    if (rises == 14) gap14 = 0;
                end
            end else begin
                ph_w++;
            end
            if (result_valid) begin
                valids++;
                last_res = result;
                chk(hi_since == HALF, "R6 valid timing after last rise", hi_since, HALF);
                if (v_p) chk(0, "R6 valid longer than one cycle", 1, 0);
            end
            cn_p = adc_cnvst_n; sc_p = adc_sclk; v_p = result_valid;
        end
    end

    // {bipolar, code, junk, expected}
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 12'h000, 4'hF, 16'h0000},
        {1'b0, 12'hFFF, 4'h0, 16'h0FFF},
        {1'b0, 12'hA5C, 4'hF, 16'h0A5C},
        {1'b0, 12'h801, 4'h0, 16'h0801},
        {1'b1, 12'h7FF, 4'hF, 16'h07FF},
        {1'b1, 12'h800, 4'h0, 16'hF800},
        {1'b1, 12'hFFF, 4'h0, 16'hFFFF},
        {1'b1, 12'h001, 4'hF, 16'h0001}
    };

    task automatic pulse_start();
        @(posedge clk); #1 start_req = 1'b1;
        @(posedge clk); #1 start_req = 1'b0;
    endtask

    task automatic wait_valids(input int target, input int limit);
        int n = 0;
        while (valids < target && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic set_frame(input logic [11:0] code, input logic [3:0] junk);
        tb_frame = {junk[3], code, junk[2:0]};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL R2 watchdog expired, frame flow hung actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base, fbase;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(adc_cnvst_n == 1'b1, "R1 reset cnvst high", adc_cnvst_n, 1);
        chk(adc_sclk == 1'b1, "R1 reset sclk high", adc_sclk, 1);
        chk(result_valid == 1'b0, "R1 reset valid low", result_valid, 0);
        chk(result == 16'h0, "R1 reset result zero", result, 0);
        repeat (40) @(negedge clk);
        chk(frames == 0, "R1 no frame without request", frames, 0);

        // R3 R4 R5: vector table
        for (int i = 0; i < NV; i++) begin
            base = valids;
            @(posedge clk); #1 bipolar = VEC[i][32];
            set_frame(VEC[i][31:20], VEC[i][19:16]);
            pulse_start();
            wait_valids(base + 1, 400);
            chk(valids == base + 1, "R3 result delivered", valids, base + 1);
            chk(last_res == VEC[i][15:0],
                VEC[i][32] ? "R5 bipolar word" : "R4 unipolar word",
                last_res, VEC[i][15:0]);
        end

        // R8: requests during a frame collapse to one pending frame
        base = valids; fbase = frames;
        @(posedge clk); #1 bipolar = 1'b0;
        set_frame(12'h3C5, 4'h9);
        pulse_start();
        repeat (10) @(posedge clk);
        pulse_start();
        repeat (20) @(posedge clk);
        pulse_start();
        pulse_start();
        wait_valids(base + 2, 800);
        repeat (300) @(negedge clk);
        chk(frames == fbase + 2, "R8 pending served once", frames, fbase + 2);
        chk(valids == base + 2, "R8 two results", valids, base + 2);
        chk(last_res == 16'h03C5, "R8 pending frame data", last_res, 16'h03C5);

        // R9: full power-down exit wait
        base = valids; fbase = frames;
        set_frame(12'h5A5, 4'h6);
        @(posedge clk); #1 wake_full = 1'b1; start_req = 1'b1;
        @(posedge clk); #1 wake_full = 1'b0; start_req = 1'b0;
        repeat (PWR / 2) @(negedge clk);
        chk(frames == fbase, "R9 no start during wait", frames, fbase);
        wait_valids(base + 1, PWR + 400);
        chk(valids == base + 1, "R9 request served after wait", valids, base + 1);
        chk(last_res == 16'h05A5, "R9 data after wait", last_res, 16'h05A5);

        // R10: partial power-down restart frame discarded
        base = valids; fbase = frames;
        @(posedge clk); #1 wake_partial = 1'b1;
        @(posedge clk); #1 wake_partial = 1'b0;
        set_frame(12'h123, 4'h0);
        pulse_start();
        repeat (200) @(negedge clk);
        chk(frames == fbase + 1, "R10 restart frame ran", frames, fbase + 1);
        chk(valids == base, "R10 restart result dropped", valids, base);
        chk(result == 16'h05A5, "R10 result held", result, 16'h05A5);
        @(posedge clk); #1 bipolar = 1'b1;
        set_frame(12'hC00, 4'hF);
        pulse_start();
        wait_valids(base + 1, 400);
        chk(valids == base + 1, "R10 next frame delivered", valids, base + 1);
        chk(last_res == 16'hFC00, "R10 next frame data", last_res, 16'hFC00);

        repeat (20) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule